// File: doc/BRIEF.md
# Block Key Storage Guard

The guard sits between the requesters of a byte-addressed storage space and the storage array, and decides in the request cycle whether each access may proceed. The space is split into equal blocks, each owning a small protection key. A processor access is allowed only when the key of the addressed block equals the program number from the current status word. A channel transfer is allowed only when that key equals the program number the guard holds for the requesting channel. Blocks that carry the same key value together form one segment, so a three-bit key allows up to eight segments.

Privileged software loads the keys, one block at a time, and loads the per-channel program numbers through a second write port. Both write ports take effect only while the privileged-mode input is high. A refused access drops its grant in the same cycle, so the storage write enable can be gated directly by the grant. The refusal also sets a sticky error interrupt that records the faulting address and its source until software clears it.

Top module: `kpu_guard`

## Requirements
- R1: After reset every block key and every channel program number is 0 and `err_irq` is 0, so a processor access with program 0 or any channel transfer is granted anywhere in the space.
- R2: The block of an access is selected by address bits [16:11]; bits [10:0] are the offset inside the 2048-byte block and do not affect the decision.
- R3: `cpu_grant` is high in the same cycle as `cpu_req` exactly when the addressed block key equals `psw_prog`; with `cpu_req` low it is 0.
- R4: `io_grant` is high in the same cycle as `io_req` exactly when the addressed block key equals the program number held for channel `io_chan`; with `io_req` low it is 0.
- R5: A key write (`key_wr_en` and `priv_mode` high) changes the key of block `key_wr_blk` at the next clock edge; an access in the same cycle still sees the old key.
- R6: A key write or a channel program write with `priv_mode` low has no effect on any later decision.
- R7: A channel program write (`chan_wr_en` and `priv_mode` high) sets the program number of channel `chan_wr_id`, used by transfers from the next cycle on.
- R8: A refused access sets `err_irq` at the next clock edge and records its address in `err_addr`, its source in `err_src_io` (0 processor, 1 channel) and, for a channel, its number in `err_chan`.
- R9: While `err_irq` is high and `err_clr` is low, later refusals leave `err_irq`, `err_addr`, `err_src_io` and `err_chan` unchanged.
- R10: When a processor access and a channel transfer are both refused in the same cycle, the channel fault is the one recorded.
- R11: `err_clr` drops `err_irq` at the next edge; a refusal in the same cycle as `err_clr` is recorded instead and keeps `err_irq` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_mode | input | 1 | Privileged mode, enables both table writes |
| key_wr_en | input | 1 | Key table write strobe |
| key_wr_blk | input | 6 | Block whose key is written |
| key_wr_val | input | 3 | Key value written |
| chan_wr_en | input | 1 | Channel program table write strobe |
| chan_wr_id | input | 3 | Channel whose program number is written |
| chan_wr_prog | input | 3 | Program number written |
| cpu_req | input | 1 | Processor access request |
| cpu_addr | input | 17 | Processor byte address |
| psw_prog | input | 3 | Program number from the current status word |
| cpu_grant | output | 1 | Processor access allowed this cycle |
| io_req | input | 1 | Channel transfer request |
| io_addr | input | 17 | Channel transfer byte address |
| io_chan | input | 3 | Requesting channel number |
| io_grant | output | 1 | Channel transfer allowed this cycle |
| err_clr | input | 1 | Clears the error interrupt |
| err_irq | output | 1 | Sticky protection error interrupt |
| err_addr | output | 17 | Address of the recorded fault |
| err_src_io | output | 1 | Source of the recorded fault, 1 for a channel |
| err_chan | output | 3 | Channel number of a recorded channel fault |

## Verification
The hardest states to reach are the cycles where two events collide: a key write and an access to the same block in one cycle, both request paths refused together, and a clear arriving together with a fresh refusal. The stimulus builds a table with distinct keys in a few blocks and distinct channel programs first, then drives each collision on purpose, choosing addresses at both ends of a block's offset range and program numbers that differ from the keys. After each collision the recorded address, source and channel are compared against the value the requirements predict.

// File: rtl/kpu_pkg.sv
package kpu_pkg;
  localparam int ADDR_W    = 17;
  localparam int BLK_BITS  = 6;
  localparam int KEY_W     = 3;
  localparam int CHAN_BITS = 3;

  typedef enum logic {
    SRC_CPU = 1'b0,
    SRC_IO  = 1'b1
  } flt_src_e;
endpackage

// File: rtl/kpu_key_table.sv
module kpu_key_table #(
  parameter int BLK_BITS = 6,
  parameter int KEY_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [BLK_BITS-1:0] wr_blk,
  input  logic [KEY_W-1:0]    wr_val,
  input  logic [BLK_BITS-1:0] rd_a_blk,
  output logic [KEY_W-1:0]    rd_a_key,
  input  logic [BLK_BITS-1:0] rd_b_blk,
  output logic [KEY_W-1:0]    rd_b_key
);
  localparam int NUM_BLK = 1 << BLK_BITS;

  logic [KEY_W-1:0] key_q [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic             ld;
    logic [KEY_W-1:0] key_d;

    always_comb begin
      ld    = wr_en && (wr_blk == BLK_BITS'(b));
      key_d = ld ? wr_val : key_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q[b] <= '0;
      else        key_q[b] <= key_d;
    end
  end

  assign rd_a_key = key_q[rd_a_blk];
  assign rd_b_key = key_q[rd_b_blk];
endmodule

// File: rtl/kpu_chan_table.sv
module kpu_chan_table #(
  parameter int CHAN_BITS = 3,
  parameter int KEY_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CHAN_BITS-1:0] wr_id,
  input  logic [KEY_W-1:0]     wr_prog,
  input  logic [CHAN_BITS-1:0] rd_id,
  output logic [KEY_W-1:0]     rd_prog
);
  localparam int NUM_CHAN = 1 << CHAN_BITS;

  logic [KEY_W-1:0] prog_q [NUM_CHAN];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic [KEY_W-1:0] prog_d;

    always_comb begin
      prog_d = (wr_en && (wr_id == CHAN_BITS'(c))) ? wr_prog : prog_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prog_q[c] <= '0;
      else        prog_q[c] <= prog_d;
    end
  end

  assign rd_prog = prog_q[rd_id];
endmodule

// File: rtl/kpu_fault_log.sv
module kpu_fault_log
  import kpu_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int CHAN_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_flt,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic                 io_flt,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic [CHAN_BITS-1:0] io_chan,
  input  logic                 clr,
  output logic                 irq,
  output logic [ADDR_W-1:0]    addr,
  output logic                 src_io,
  output logic [CHAN_BITS-1:0] chan
);
  logic                 irq_q, irq_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  flt_src_e             src_q, src_d;
  logic [CHAN_BITS-1:0] chan_q, chan_d;
  logic                 open;
  logic                 cap;

  always_comb begin
    open   = !irq_q || clr;
    cap    = open && (cpu_flt || io_flt);
    irq_d  = irq_q;
    addr_d = addr_q;
    src_d  = src_q;
    chan_d = chan_q;
    if (cap) begin
      irq_d = 1'b1;
      if (io_flt) begin
        addr_d = io_addr;
        src_d  = SRC_IO;
        chan_d = io_chan;
      end else begin
        addr_d = cpu_addr;
        src_d  = SRC_CPU;
        chan_d = '0;
      end
    end else if (clr) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      addr_q <= '0;
      src_q  <= SRC_CPU;
      chan_q <= '0;
    end else begin
      irq_q  <= irq_d;
      addr_q <= addr_d;
      src_q  <= src_d;
      chan_q <= chan_d;
    end
  end

  assign irq    = irq_q;
  assign addr   = addr_q;
  assign src_io = (src_q == SRC_IO);
  assign chan   = chan_q;
endmodule

// File: rtl/kpu_guard.sv
module kpu_guard
  import kpu_pkg::*;
#(
  parameter int AW  = kpu_pkg::ADDR_W,
  parameter int BB  = kpu_pkg::BLK_BITS,
  parameter int KW  = kpu_pkg::KEY_W,
  parameter int CB  = kpu_pkg::CHAN_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          priv_mode,
  input  logic          key_wr_en,
  input  logic [BB-1:0] key_wr_blk,
  input  logic [KW-1:0] key_wr_val,
  input  logic          chan_wr_en,
  input  logic [CB-1:0] chan_wr_id,
  input  logic [KW-1:0] chan_wr_prog,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic [KW-1:0] psw_prog,
  output logic          cpu_grant,
  input  logic          io_req,
  input  logic [AW-1:0] io_addr,
  input  logic [CB-1:0] io_chan,
  output logic          io_grant,
  input  logic          err_clr,
  output logic          err_irq,
  output logic [AW-1:0] err_addr,
  output logic          err_src_io,
  output logic [CB-1:0] err_chan
);
  localparam int OFS_BITS = AW - BB;

  logic          key_ld, chan_ld;
  logic [BB-1:0] cpu_blk, io_blk;
  logic [KW-1:0] cpu_key, io_key, io_prog;
  logic          cpu_flt, io_flt;

  always_comb begin
    key_ld  = key_wr_en && priv_mode;
    chan_ld = chan_wr_en && priv_mode;
    cpu_blk = cpu_addr[AW-1:OFS_BITS];
    io_blk  = io_addr[AW-1:OFS_BITS];
  end

  kpu_key_table #(.BLK_BITS(BB), .KEY_W(KW)) i_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (key_ld),
    .wr_blk   (key_wr_blk),
    .wr_val   (key_wr_val),
    .rd_a_blk (cpu_blk),
    .rd_a_key (cpu_key),
    .rd_b_blk (io_blk),
    .rd_b_key (io_key)
  );

  kpu_chan_table #(.CHAN_BITS(CB), .KEY_W(KW)) i_chans (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (chan_ld),
    .wr_id   (chan_wr_id),
    .wr_prog (chan_wr_prog),
    .rd_id   (io_chan),
    .rd_prog (io_prog)
  );

  always_comb begin
    cpu_grant = cpu_req && (cpu_key == psw_prog);
    io_grant  = io_req && (io_key == io_prog);
    cpu_flt   = cpu_req && !cpu_grant;
    io_flt    = io_req && !io_grant;
  end

  kpu_fault_log #(.ADDR_W(AW), .CHAN_BITS(CB)) i_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_flt  (cpu_flt),
    .cpu_addr (cpu_addr),
    .io_flt   (io_flt),
    .io_addr  (io_addr),
    .io_chan  (io_chan),
    .clr      (err_clr),
    .irq      (err_irq),
    .addr     (err_addr),
    .src_io   (err_src_io),
    .chan     (err_chan)
  );
endmodule

// File: rtl/kpu_guard_chk.sv
module kpu_guard_chk #(
  parameter int AW = 17,
  parameter int CB = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_grant,
  input logic          io_req,
  input logic          io_grant,
  input logic [AW-1:0] cpu_addr,
  input logic          err_clr,
  input logic          err_irq,
  input logic [AW-1:0] err_addr,
  input logic          err_src_io,
  input logic [CB-1:0] err_chan
);
  // R3
  cpu_grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_grant |-> cpu_req);

  // R4
  io_grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_grant |-> io_req);

  // R8
  cpu_deny_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_grant) |=> err_irq);

  // R8
  io_deny_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_grant) |=> err_irq);

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !err_clr) |=> err_irq);

  // R9
  record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !err_clr) |=> ($stable(err_addr) && $stable(err_src_io) && $stable(err_chan)));

  // R11
  clr_quiet_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(cpu_req && !cpu_grant) && !(io_req && !io_grant)) |=> !err_irq);

  // R8
  cpu_fault_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_irq && cpu_req && !cpu_grant && !(io_req && !io_grant))
      |=> (err_addr == $past(cpu_addr) && !err_src_io));
endmodule

bind kpu_guard kpu_guard_chk #(.AW(AW), .CB(CB)) i_kpu_guard_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .cpu_grant  (cpu_grant),
  .io_req     (io_req),
  .io_grant   (io_grant),
  .cpu_addr   (cpu_addr),
  .err_clr    (err_clr),
  .err_irq    (err_irq),
  .err_addr   (err_addr),
  .err_src_io (err_src_io),
  .err_chan   (err_chan)
);

// File: tb/test_kpu_guard.sv
module test_kpu_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        priv_mode, key_wr_en, chan_wr_en;
  logic [5:0]  key_wr_blk;
  logic [2:0]  key_wr_val, chan_wr_id, chan_wr_prog;
  logic        cpu_req, io_req, err_clr;
  logic [16:0] cpu_addr, io_addr;
  logic [2:0]  psw_prog, io_chan;
  logic        cpu_grant, io_grant, err_irq, err_src_io;
  logic [16:0] err_addr;
  logic [2:0]  err_chan;

  kpu_guard i_kpu_guard (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
    .key_wr_en(key_wr_en), .key_wr_blk(key_wr_blk), .key_wr_val(key_wr_val),
    .chan_wr_en(chan_wr_en), .chan_wr_id(chan_wr_id), .chan_wr_prog(chan_wr_prog),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .psw_prog(psw_prog), .cpu_grant(cpu_grant),
    .io_req(io_req), .io_addr(io_addr), .io_chan(io_chan), .io_grant(io_grant),
    .err_clr(err_clr), .err_irq(err_irq), .err_addr(err_addr),
    .err_src_io(err_src_io), .err_chan(err_chan)
  );

  always #10 clk = ~clk;

  typedef enum int {K_CPU_GNT, K_IO_GNT, K_IRQ, K_ADDR, K_SRC, K_CHAN} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  function automatic logic [16:0] ad(input int blk, input int ofs);
    return {blk[5:0], ofs[10:0]};
  endfunction

  task automatic expect_v(input kind_e k, input logic [31:0] v, input string r);
    item_t it;
    it.kind = k; it.exp = v; it.req = r;
    q.push_back(it);
  endtask

  task automatic clear_in();
    priv_mode = 0; key_wr_en = 0; key_wr_blk = '0; key_wr_val = '0;
    chan_wr_en = 0; chan_wr_id = '0; chan_wr_prog = '0;
    cpu_req = 0; cpu_addr = '0; psw_prog = '0;
    io_req = 0; io_addr = '0; io_chan = '0; err_clr = 0;
  endtask

  task automatic next_cyc();
    @(negedge clk);
    clear_in();
  endtask

  // Monitor: pops expected items mid-phase after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_CPU_GNT: act = 32'(cpu_grant);
          K_IO_GNT:  act = 32'(io_grant);
          K_IRQ:     act = 32'(err_irq);
          K_ADDR:    act = 32'(err_addr);
          K_SRC:     act = 32'(err_src_io);
          default:   act = 32'(err_chan);
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s: actual %0h expected %0h", it.req, it.kind.name(), act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, keys and channel programs all zero
    next_cyc();
    cpu_req = 1; cpu_addr = 17'h1FFFF; psw_prog = 0;
    io_req = 1; io_addr = 17'h00000; io_chan = 5;
    expect_v(K_IRQ, 0, "R1");
    expect_v(K_CPU_GNT, 1, "R1");
    expect_v(K_IO_GNT, 1, "R1");

    // R5: key write to block 3, same-cycle access still sees old key 0
    next_cyc();
    priv_mode = 1; key_wr_en = 1; key_wr_blk = 3; key_wr_val = 5;
    cpu_req = 1; cpu_addr = ad(3, 11'h7FF); psw_prog = 0;
    expect_v(K_CPU_GNT, 1, "R5");

    // R2 R5: new key visible, both ends of block 3
    next_cyc();
    cpu_req = 1; cpu_addr = ad(3, 0); psw_prog = 5;
    io_req = 1; io_addr = ad(4, 11'h7FF); io_chan = 2;
    expect_v(K_CPU_GNT, 1, "R2");
    expect_v(K_IO_GNT, 1, "R2");

    // R6: unprivileged writes
    next_cyc();
    key_wr_en = 1; key_wr_blk = 4; key_wr_val = 6;
    chan_wr_en = 1; chan_wr_id = 2; chan_wr_prog = 6;
    next_cyc();
    cpu_req = 1; cpu_addr = ad(4, 5); psw_prog = 0;
    io_req = 1; io_addr = ad(4, 6); io_chan = 2;
    expect_v(K_CPU_GNT, 1, "R6");
    expect_v(K_IO_GNT, 1, "R6");

    // R7: privileged channel write and key write
    next_cyc();
    priv_mode = 1; chan_wr_en = 1; chan_wr_id = 2; chan_wr_prog = 5;
    key_wr_en = 1; key_wr_blk = 4; key_wr_val = 2;
    next_cyc();
    io_req = 1; io_addr = ad(3, 5); io_chan = 2;
    cpu_req = 1; cpu_addr = ad(4, 0); psw_prog = 2;
    expect_v(K_IO_GNT, 1, "R7");
    expect_v(K_CPU_GNT, 1, "R3");
    expect_v(K_IRQ, 0, "R3");

    // R3: processor refusal, then R8 record
    next_cyc();
    cpu_req = 1; cpu_addr = ad(3, 11'h123); psw_prog = 1;
    expect_v(K_CPU_GNT, 0, "R3");
    next_cyc();
    expect_v(K_IRQ, 1, "R8");
    expect_v(K_ADDR, 32'(ad(3, 11'h123)), "R8");
    expect_v(K_SRC, 0, "R8");

    // R4: channel refusal while pending, R9 record unchanged
    next_cyc();
    io_req = 1; io_addr = ad(4, 11'h010); io_chan = 2;
    expect_v(K_IO_GNT, 0, "R4");
    next_cyc();
    expect_v(K_IRQ, 1, "R9");
    expect_v(K_ADDR, 32'(ad(3, 11'h123)), "R9");
    expect_v(K_SRC, 0, "R9");

    // R11: clear alone
    next_cyc();
    err_clr = 1;
    next_cyc();
    expect_v(K_IRQ, 0, "R11");

    // R10: both paths refused together
    next_cyc();
    cpu_req = 1; cpu_addr = ad(4, 1); psw_prog = 7;
    io_req = 1; io_addr = ad(3, 2); io_chan = 0;
    next_cyc();
    expect_v(K_IRQ, 1, "R10");
    expect_v(K_SRC, 1, "R10");
    expect_v(K_CHAN, 0, "R10");
    expect_v(K_ADDR, 32'(ad(3, 2)), "R10");

    // R11: clear together with a new processor refusal
    next_cyc();
    err_clr = 1; cpu_req = 1; cpu_addr = ad(5, 9); psw_prog = 3;
    next_cyc();
    expect_v(K_IRQ, 1, "R11");
    expect_v(K_ADDR, 32'(ad(5, 9)), "R11");
    expect_v(K_SRC, 0, "R11");

    // R8: channel fault records channel number
    next_cyc();
    err_clr = 1;
    next_cyc();
    io_req = 1; io_addr = ad(4, 11'h010); io_chan = 2;
    next_cyc();
    expect_v(K_SRC, 1, "R8");
    expect_v(K_CHAN, 2, "R8");
    expect_v(K_ADDR, 32'(ad(4, 11'h010)), "R8");

    // R3 R4: no request, no grant
    next_cyc();
    cpu_addr = ad(0, 0); psw_prog = 0; io_addr = ad(0, 0); io_chan = 0;
    expect_v(K_CPU_GNT, 0, "R3");
    expect_v(K_IO_GNT, 0, "R4");

    next_cyc();
    next_cyc();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule